// File: doc/BRIEF.md
# TMDS Control-Character Word Aligner

The block takes the 10-bit words from a deserializer whose word boundary can sit at any bit. It finds the true symbol boundary by looking for one of the four TMDS control characters at each of the ten bit offsets. On the first hit it freezes that offset and reports lock. From then on it emits realigned symbols with a valid strobe. It also reports the chosen offset and which control character produced the lock.

Alignment happens once for each arming of the enable. While the enable is high and the aligner is unlocked, every incoming word is searched. The first match locks the aligner and searching stops. Further commas at any offset are ignored. To realign, the enable must be brought low for at least one clock, which clears the lock, and then raised again. The block suits the control-character preamble that comes before video and data-island periods, where the same comma repeats several times in a row.

Top module: `tmds_word_aligner`

## Requirements
- R1: A synchronous reset clears lock and valid, sets the offset and the code report to 0, and empties the two-word history. This holds whatever level the enable has.
- R2: The comma set is given below, written bit 9 down to bit 0. `code_o` reports which entry produced the lock: 0 = 1101010100, 1 = 0010101011, 2 = 0101010100, 3 = 1010101011.
- R3: Bit 0 of each raw word is the earliest bit in the serial stream. The search window is {later word, earlier word}, 20 bits wide. Offset k selects window bits k+9 down to k, and `offset_o` reports k in the range 0 to 9.
- R4: Suppose the enable is high, the block is unlocked, and the words sampled at edges n and n+1 hold a comma at offset k. Then after edge n+2, lock and valid are 1, `offset_o` is k, and `sym_o` is that comma.
- R5: Suppose the enable is sampled low at an edge. Then lock and valid are 0 after that edge, and no comma is acquired while the enable stays low.
- R6: While locked with the enable held high, lock, `offset_o` and `code_o` stay unchanged. This holds for any data, including commas at other offsets.
- R7: After the enable has been low for at least one edge and is then high again, the search resumes. The next comma found sets a new offset and code.
- R8: If commas match at several offsets of the same window, the lowest offset is taken.
- R9: The valid strobe equals the lock state. While valid, each edge delivers the slice at the locked offset of the two words sampled at the previous two edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Parallel word clock |
| rst | input | 1 | Synchronous active-high reset |
| raw_i | input | 10 | Raw deserialized word, bit 0 earliest |
| align_en_i | input | 1 | Search enable; low clears lock, high arms a search |
| sym_o | output | 10 | Realigned symbol |
| sym_vld_o | output | 1 | Symbol valid, high while locked |
| locked_o | output | 1 | Alignment lock flag |
| offset_o | output | 4 | Locked bit offset, 0 to 9 |
| code_o | output | 2 | Control character that produced the lock |

## Verification
A wrong offset register shows at the ports one edge after lock. The first valid symbol is then not a control character, and every later symbol is a shifted copy of the stimulus. A lock flag that re-arms while the enable stays high shows as an offset or code change the first time a misaligned comma arrives. A lock flag that ignores a low enable shows as valid still high on the edge after the enable was sampled low. A bad history register or a bad priority shows up in the lock cycle itself, because the offset and code are compared there against a reference computed from the stimulus stream.

// File: rtl/tmds_word_aligner.sv
module tmds_word_aligner (
  input  logic       clk,
  input  logic       rst,
  input  logic [9:0] raw_i,
  input  logic       align_en_i,
  output logic [9:0] sym_o,
  output logic       sym_vld_o,
  output logic       locked_o,
  output logic [3:0] offset_o,
  output logic [1:0] code_o
);
  localparam int SYM_W = 10;
  localparam int OFF_W = 4;
  localparam logic [SYM_W-1:0] CTL0 = 10'b1101010100;
  localparam logic [SYM_W-1:0] CTL1 = 10'b0010101011;
  localparam logic [SYM_W-1:0] CTL2 = 10'b0101010100;
  localparam logic [SYM_W-1:0] CTL3 = 10'b1010101011;

  logic [SYM_W-1:0]   w_new, w_old;
  logic [2*SYM_W-1:0] win;
  logic [SYM_W-1:0]   hit_vec;
  logic [1:0]         hcode [SYM_W];
  logic [OFF_W-1:0]   f_off, sel;
  logic [1:0]         f_code;
  logic               take, lock_nx;

  assign win = {w_new, w_old};

  for (genvar k = 0; k < SYM_W; k++) begin : g_off
    logic [SYM_W-1:0] slc;
    logic m0, m1, m2, m3;
    assign slc = win[k +: SYM_W];
    assign m0 = (slc == CTL0);
    assign m1 = (slc == CTL1);
    assign m2 = (slc == CTL2);
    assign m3 = (slc == CTL3);
    assign hit_vec[k] = m0 | m1 | m2 | m3;
    assign hcode[k] = {m2 | m3, m1 | m3};
  end

  always_comb begin
    f_off  = '0;
    f_code = '0;
    for (int k = SYM_W - 1; k >= 0; k--) begin
      if (hit_vec[k]) begin
        f_off  = OFF_W'(k);
        f_code = hcode[k];
      end
    end
  end

  assign take    = align_en_i & ~locked_o & (|hit_vec);
  assign lock_nx = align_en_i & (locked_o | take);
  assign sel     = take ? f_off : offset_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_new     <= '0;
      w_old     <= '0;
      locked_o  <= 1'b0;
      sym_vld_o <= 1'b0;
      offset_o  <= '0;
      code_o    <= '0;
      sym_o     <= '0;
    end else begin
      w_new     <= raw_i;
      w_old     <= w_new;
      locked_o  <= lock_nx;
      sym_vld_o <= lock_nx;
      sym_o     <= SYM_W'(win >> sel);
      if (take) begin
        offset_o <= f_off;
        code_o   <= f_code;
      end
    end
  end
endmodule

module tmds_word_aligner_chk (
  input logic       clk,
  input logic       rst,
  input logic       align_en_i,
  input logic [9:0] sym_o,
  input logic       sym_vld_o,
  input logic       locked_o,
  input logic [3:0] offset_o,
  input logic [1:0] code_o
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!locked_o && !sym_vld_o && offset_o == 4'd0 && code_o == 2'd0)); // R1

  AST_FIRST_SYM_IS_CODE: assert property (@(posedge clk) disable iff (rst)
    $rose(sym_vld_o) |-> ((code_o == 2'd0 && sym_o == 10'b1101010100) ||
                          (code_o == 2'd1 && sym_o == 10'b0010101011) ||
                          (code_o == 2'd2 && sym_o == 10'b0101010100) ||
                          (code_o == 2'd3 && sym_o == 10'b1010101011))); // R2

  AST_OFFSET_RANGE: assert property (@(posedge clk) disable iff (rst)
    offset_o <= 4'd9); // R3

  AST_EN_LOW_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !align_en_i |=> !locked_o); // R5

  AST_LOCK_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    $rose(locked_o) |-> $past(align_en_i)); // R5

  AST_HOLD_LOCK: assert property (@(posedge clk) disable iff (rst)
    (locked_o && align_en_i) |=> locked_o); // R6

  AST_OFFSET_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (locked_o && $past(locked_o)) |-> ($stable(offset_o) && $stable(code_o))); // R6
endmodule

bind tmds_word_aligner tmds_word_aligner_chk u_chk (.*);

// File: tb/sim_tmds_word_aligner.sv
module sim_tmds_word_aligner;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst = 1'b1;
  logic       en = 1'b0;
  logic [9:0] raw = '0;
  logic [9:0] sym_o;
  logic       sym_vld_o, locked_o;
  logic [3:0] offset_o;
  logic [1:0] code_o;

  tmds_word_aligner u0 (
    .clk(clk), .rst(rst), .raw_i(raw), .align_en_i(en),
    .sym_o(sym_o), .sym_vld_o(sym_vld_o), .locked_o(locked_o),
    .offset_o(offset_o), .code_o(code_o)
  );

  int total = 0;
  int bad = 0;

  typedef struct {
    logic       vld;
    logic       lk;
    logic [3:0] off;
    logic [1:0] code;
    logic [9:0] sym;
    string      tag;
  } exp_t;
  exp_t q[$];

  logic [9:0] m_new = '0, m_old = '0;
  logic       m_lk = 1'b0;
  logic [3:0] m_off = '0;
  logic [1:0] m_code = '0;

  function automatic logic [9:0] ctl(int i);
    case (i)
      0: return 10'b1101010100;
      1: return 10'b0010101011;
      2: return 10'b0101010100;
      default: return 10'b1010101011;
    endcase
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, expv);
    end
  endtask

  task automatic step(logic [9:0] w, logic e, logic r, string tag);
    exp_t x;
    logic [19:0] win;
    bit found, take;
    int fo, fc;
    @(negedge clk);
    raw = w; en = e; rst = r;
    if (r) begin
      m_new = '0; m_old = '0; m_lk = 1'b0; m_off = '0; m_code = '0;
      x.vld = 1'b0; x.sym = '0;
    end else begin
      win = {m_new, m_old};
      found = 1'b0; fo = 0; fc = 0;
      for (int k = 0; k < 10 && !found; k++)
        for (int c = 0; c < 4; c++)
          if (win[k +: 10] == ctl(c)) begin found = 1'b1; fo = k; fc = c; end
      take = e && !m_lk && found;
      if (take) begin m_off = 4'(fo); m_code = 2'(fc); end
      m_lk = e && (m_lk || take);
      x.sym = 10'(win >> m_off);
      x.vld = m_lk;
      m_old = m_new;
      m_new = w;
    end
    x.lk = m_lk; x.off = m_off; x.code = m_code; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic send_at(int c, int s, logic e, string tag);
    logic [19:0] t;
    t = 20'(ctl(c)) << s;
    step(t[9:0], e, 1'b0, tag);
    step(t[19:10], e, 1'b0, tag);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t x;
        x = q.pop_front();
        chk(locked_o === x.lk, x.tag, "lock", locked_o, x.lk);
        chk(sym_vld_o === x.vld, x.tag, "valid", sym_vld_o, x.vld);
        chk(offset_o === x.off, x.tag, "offset", offset_o, x.off);
        if (x.lk) chk(code_o === x.code, x.tag, "code", code_o, x.code);
        if (x.vld) chk(sym_o === x.sym, x.tag, "sym", sym_o, x.sym);
      end
    end
  end

  initial begin
    #100000;
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset with enable high
    for (int i = 0; i < 3; i++) step(10'h3FF, 1'b1, 1'b1, "R1");
    step(10'h000, 1'b0, 1'b0, "R1");
    chk(!locked_o && !sym_vld_o && offset_o == 0, "R1", "reset state", locked_o, 0);

    // R5: comma while enable low is not acquired
    send_at(2, 5, 1'b0, "R5");
    for (int i = 0; i < 3; i++) step(10'h000, 1'b0, 1'b0, "R5");
    chk(locked_o == 1'b0, "R5", "no lock while low", locked_o, 0);

    // R3 R4 R2: comma 00 at offset 3
    step(10'h000, 1'b1, 1'b0, "R4");
    send_at(0, 3, 1'b1, "R4");
    step(10'h000, 1'b1, 1'b0, "R4");
    step(10'h000, 1'b1, 1'b0, "R4");
    chk(offset_o == 4'd3, "R3", "offset", offset_o, 3);
    chk(code_o == 2'd0, "R2", "code", code_o, 0);

    // R6: misaligned comma and payload ignored
    send_at(2, 7, 1'b1, "R6");
    for (int i = 0; i < 6; i++) step(10'($urandom), 1'b1, 1'b0, "R6");
    chk(offset_o == 4'd3 && locked_o, "R6", "frozen offset", offset_o, 3);

    // R9: payload delivered at locked offset
    for (int i = 0; i < 20; i++) step(10'($urandom), 1'b1, 1'b0, "R9");

    // R5: one-cycle low clears lock
    step(10'h000, 1'b0, 1'b0, "R5");
    step(10'h000, 1'b1, 1'b0, "R5");
    chk(!locked_o && !sym_vld_o, "R5", "cleared", locked_o, 0);

    // R7: preamble of code 11 at offset 6
    step(10'h000, 1'b1, 1'b0, "R7");
    step(10'h000, 1'b1, 1'b0, "R7");
    begin
      logic [9:0] c, w0, wr;
      c = ctl(3);
      w0 = 10'(c << 6);
      for (int i = 0; i < 10; i++) wr[i] = c[(i + 4) % 10];
      step(w0, 1'b1, 1'b0, "R7");
      for (int i = 0; i < 8; i++) step(wr, 1'b1, 1'b0, "R7");
    end
    chk(offset_o == 4'd6 && code_o == 2'd3 && locked_o, "R7", "relock", offset_o, 6);
    for (int i = 0; i < 10; i++) step(10'($urandom), 1'b1, 1'b0, "R9");

    // R8: matches at offsets 0 and 8 in one window
    step(10'h000, 1'b0, 1'b0, "R8");
    step(10'h000, 1'b1, 1'b0, "R8");
    step(10'h000, 1'b1, 1'b0, "R8");
    step(10'h0AB, 1'b1, 1'b0, "R8");
    step(10'h055, 1'b1, 1'b0, "R8");
    step(10'h000, 1'b1, 1'b0, "R8");
    step(10'h000, 1'b1, 1'b0, "R8");
    chk(offset_o == 4'd0 && code_o == 2'd1 && locked_o, "R8", "lowest offset", offset_o, 0);

    // R1: reset while locked and enabled
    step(10'h2AA, 1'b1, 1'b1, "R1");
    step(10'h2AA, 1'b1, 1'b0, "R1");
    chk(!locked_o && !sym_vld_o && offset_o == 0, "R1", "reset while locked", locked_o, 0);

    @(posedge clk);
    #2;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule